// File: doc/BRIEF.md
# Timer-Compare Half-Duplex Serial Port

This block moves single bytes over a two-wire asynchronous serial link. It uses one free-running tick counter for all of its timing and has no baud divider. The transmit channel keeps a compare target on that counter. When the counter reaches the target, the channel drives the next bit onto the line and moves the target one bit-time further on. The receive channel records the counter value when it sees the falling start edge. It then places its sampling points relative to that timestamp: the first data sample falls one and a half bit-times later, and each following sample is one bit-time after the one before.

The counter advances once per clock, so the bit-time in clock cycles is the clock frequency divided by the baud rate. For example, a 1 MHz tick at 2400 baud gives about 417. Only one direction runs at a time. While a byte goes out, the receive line is ignored. While a byte comes in, transmit requests are refused.

A frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit. The line rests high.

Top module: `tuart_top`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0, `rx_strobe` is 0 and `rx_frame_err` is 0.
- R2: A request accepted at a clock edge drives `txd` low from that edge. `txd` then carries data bit 0 first through data bit 7, then a 1. Each of these ten levels lasts exactly `bit_ticks` cycles.
- R3: `busy` is high for exactly 10×`bit_ticks` cycles after the accepting edge. A `tx_valid` pulse while `busy` is high is ignored and never produces a frame.
- R4: The receiver detects a falling edge on `rxd` after a two-flop synchronizer. It samples data bit k at 1.5+k bit-times after the detected edge and the stop bit at 9.5 bit-times. `rx_strobe` is high for one cycle with `rx_byte`, 9×`bit_ticks`+1 to 10×`bit_ticks` cycles after the line falls.
- R5: `rx_frame_err` is updated with every `rx_strobe`. It is 1 when the stop sample was 0 and 0 otherwise, and the byte is delivered in both cases.
- R6: Transmit and receive never overlap. `rxd` activity during a transmit frame yields no `rx_strobe`. A request during a receive frame leaves `txd` high.
- R7: `bit_ticks` is captured when a frame starts. Changing it during the frame does not change that frame's timing.
- R8: Outside a transmit frame, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the tick counter advances every cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_ticks | input | 16 | Bit-time in clock cycles (at least 8) |
| tx_valid | input | 1 | Request to send `tx_byte` |
| tx_byte | input | 8 | Byte to send |
| busy | output | 1 | A frame is in progress in either direction |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_strobe | output | 1 | One-cycle pulse: a received byte is valid |
| rx_byte | output | 8 | Last received byte |
| rx_frame_err | output | 1 | Stop bit of the last received byte was 0 |

## Verification
A wrong compare target or a missed counter match makes a transmitted bit the wrong length. That shows on `txd` within one bit-time, at the mid-bit sample the bench takes. If the receive timestamp or the sample offset is wrong, the sampling points drift toward bit boundaries. A shuffled or shifted `rx_byte`, or a strobe outside its window, then appears at the end of the same frame. A broken half-duplex interlock shows as a spurious strobe, or a `txd` low pulse, within the frame that should have been left alone.

// File: rtl/tuart_pkg.sv
package tuart_pkg;
  localparam int TICK_W = 16;
  localparam int DATA_W = 8;
  typedef logic [TICK_W-1:0] tick_t;

  // Next compare target: one bit-time past the base stamp (wraps modulo 2^TICK_W).
  function automatic tick_t next_edge(tick_t base, tick_t span);
    return base + span;
  endfunction

  // First receive sample: one and a half bit-times past the start-edge stamp.
  function automatic tick_t first_sample(tick_t base, tick_t span);
    return base + span + (span >> 1);
  endfunction
endpackage

// File: rtl/tuart_timebase.sv
module tuart_timebase
  import tuart_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output tick_t count
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count + tick_t'(1);
  end

  assert_count_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> count == $past(count) + tick_t'(1));
endmodule

// File: rtl/tuart_txchan.sv
module tuart_txchan
  import tuart_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tick_t         count,
  input  tick_t         bit_ticks,
  input  logic          go,
  input  logic [DW-1:0] data,
  output logic          txd,
  output logic          active,
  output logic          hit
);
  localparam int IDX_W = $clog2(DW + 2);

  tick_t          target;
  tick_t          span_q;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]  shreg;

  assign hit = active && (count == target);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txd    <= 1'b1;
      active <= 1'b0;
      target <= '0;
      span_q <= '0;
      idx    <= '0;
      shreg  <= '0;
    end else if (!active) begin
      if (go) begin
        active <= 1'b1;
        txd    <= 1'b0;
        idx    <= '0;
        shreg  <= data;
        span_q <= bit_ticks;
        target <= next_edge(count, bit_ticks);
      end
    end else if (hit) begin
      target <= next_edge(target, span_q);
      if (idx < IDX_W'(DW)) begin
        txd   <= shreg[0];
        shreg <= shreg >> 1;
        idx   <= idx + 1'b1;
      end else if (idx == IDX_W'(DW)) begin
        txd <= 1'b1;
        idx <= idx + 1'b1;
      end else begin
        active <= 1'b0;
      end
    end
  end

  assert_idle_line_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> txd);
  assert_edge_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(hit || go));
  assert_span_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && active) |-> $stable(span_q));
endmodule

// File: rtl/tuart_rxchan.sv
module tuart_rxchan
  import tuart_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tick_t         count,
  input  tick_t         bit_ticks,
  input  logic          block,
  input  logic          rxd,
  output logic          active,
  output logic          strobe,
  output logic [DW-1:0] byte_out,
  output logic          frame_err,
  output logic          fall_ev,
  output logic          hit
);
  localparam int IDX_W = $clog2(DW + 1);

  logic [1:0]       sync;
  logic             prev;
  tick_t            target;
  tick_t            span_q;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    shreg;

  assign fall_ev = prev && !sync[1];
  assign hit     = active && (count == target);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync <= 2'b11;
      prev <= 1'b1;
    end else begin
      sync <= {sync[0], rxd};
      prev <= sync[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      strobe    <= 1'b0;
      byte_out  <= '0;
      frame_err <= 1'b0;
      target    <= '0;
      span_q    <= '0;
      idx       <= '0;
      shreg     <= '0;
    end else begin
      strobe <= 1'b0;
      if (!active) begin
        if (fall_ev && !block) begin
          active <= 1'b1;
          idx    <= '0;
          span_q <= bit_ticks;
          target <= first_sample(count, bit_ticks);
        end
      end else if (hit) begin
        target <= next_edge(target, span_q);
        if (idx < IDX_W'(DW)) begin
          shreg <= {sync[1], shreg[DW-1:1]};
          idx   <= idx + 1'b1;
        end else begin
          byte_out  <= shreg;
          frame_err <= !sync[1];
          strobe    <= 1'b1;
          active    <= 1'b0;
        end
      end
    end
  end

  assert_strobe_after_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> $past(active) && !active);
  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
  assert_err_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_err) |-> strobe);
endmodule

// File: rtl/tuart_top.sv
module tuart_top
  import tuart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] bit_ticks,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              busy,
  output logic              txd,
  input  logic              rxd,
  output logic              rx_strobe,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_frame_err
);
  tick_t count;
  logic  tx_active, rx_active, tx_go, tx_hit, rx_hit, rx_fall;

  assign tx_go = tx_valid && !tx_active && !rx_active;
  assign busy  = tx_active || rx_active;

  tuart_timebase u_time (.clk(clk), .rst_n(rst_n), .count(count));

  tuart_txchan #(.DW(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .count(count), .bit_ticks(bit_ticks),
    .go(tx_go), .data(tx_byte), .txd(txd), .active(tx_active), .hit(tx_hit));

  tuart_rxchan #(.DW(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .count(count), .bit_ticks(bit_ticks),
    .block(tx_active || tx_go), .rxd(rxd), .active(rx_active),
    .strobe(rx_strobe), .byte_out(rx_byte), .frame_err(rx_frame_err),
    .fall_ev(rx_fall), .hit(rx_hit));

  assert_half_duplex_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_active && rx_active));
  assert_no_strobe_in_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_active) |-> !rx_strobe);
  assert_busy_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_active) |=> (txd || !rx_active));
endmodule

// File: tb/sim_tuart_top.sv
module sim_tuart_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bit_ticks = 16'd16;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_byte = 8'h00;
  logic        busy, txd, rx_strobe, rx_frame_err;
  logic        rxd = 1'b1;
  logic [7:0]  rx_byte;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int strobe_cnt = 0;
  int strobe_cyc = 0;
  logic [7:0] got_byte;
  logic       got_err;

  always #5 clk = ~clk;

  tuart_top u0 (.clk(clk), .rst_n(rst_n), .bit_ticks(bit_ticks),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .busy(busy), .txd(txd),
    .rxd(rxd), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
    .rx_frame_err(rx_frame_err));

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rx_strobe) begin
    strobe_cnt <= strobe_cnt + 1;
    strobe_cyc <= cyc;
    got_byte   <= rx_byte;
    got_err    <= rx_frame_err;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic frame_bit(input logic [7:0] b, input int j, input logic stopv);
    if (j == 0) return 1'b0;
    if (j <= 8) return b[j-1];
    return stopv;
  endfunction

  // mode 0 plain, 1 ignored request + bit_ticks change (R3, R7), 2 rxd glitch (R6)
  task automatic tx_run(input logic [7:0] b, input int bt, input int mode);
    int s0;
    s0 = strobe_cnt;
    @(negedge clk);
    bit_ticks = 16'(bt); tx_byte = b; tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    for (int k = 0; k <= 10*bt; k++) begin
      if (k % bt == bt/2 && k < 10*bt)
        chk($sformatf("R2 bit %0d", k/bt), int'(txd), int'(frame_bit(b, k/bt, 1'b1)));
      if (k == 10*bt-1) chk("R3 busy last", int'(busy), 1);
      if (k == 10*bt)   chk("R3 busy clear", int'(busy), 0);
      if (mode == 1 && k == 3*bt)   begin tx_valid = 1'b1; tx_byte = ~b; bit_ticks = 16'(bt+7); end
      if (mode == 1 && k == 3*bt+1) tx_valid = 1'b0;
      if (mode == 2 && k == 2*bt)   rxd = 1'b0;
      if (mode == 2 && k == 2*bt+5) rxd = 1'b1;
      @(negedge clk);
    end
    begin
      int lows = 0;
      for (int k = 0; k < 2*bt; k++) begin
        if (!txd || busy) lows++;
        @(negedge clk);
      end
      chk("R8 idle after frame / R3 no second frame", lows, 0);
    end
    if (mode == 2) chk("R6 no strobe during tx", strobe_cnt - s0, 0);
  endtask

  // mode 1: transmit request in the middle of the frame (R6)
  task automatic rx_run(input logic [7:0] b, input int bt, input logic stopv, input int mode);
    int s0, c0, lows;
    s0 = strobe_cnt; lows = 0;
    @(negedge clk);
    bit_ticks = 16'(bt);
    c0 = cyc;
    for (int k = 0; k < 10*bt; k++) begin
      if (k % bt == 0) rxd = frame_bit(b, k/bt, stopv);
      if (mode == 1 && k == 3*bt) begin
        chk("R6 busy during rx", int'(busy), 1);
        tx_valid = 1'b1; tx_byte = 8'h00;
      end
      if (mode == 1 && k == 3*bt+1) tx_valid = 1'b0;
      if (!txd) lows++;
      @(negedge clk);
    end
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 one strobe", strobe_cnt - s0, 1);
    chk("R4 byte", int'(got_byte), int'(b));
    chk("R5 frame err flag", int'(got_err), int'(!stopv));
    chk("R4 strobe window", int'((strobe_cyc - c0) >= 9*bt+1 && (strobe_cyc - c0) <= 10*bt), 1);
    if (mode == 1) chk("R6 txd held high during rx", lows, 0);
    repeat (bt) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd", int'(txd), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 strobe", int'(rx_strobe), 0);
    chk("R1 ferr", int'(rx_frame_err), 0);
    tx_run(8'hA5, 16, 0);
    tx_run(8'h3C, 23, 1);
    tx_run(8'h01, 16, 2);
    rx_run(8'h5A, 16, 1'b1, 0);
    rx_run(8'hC3, 21, 1'b1, 1);
    rx_run(8'h7E, 16, 1'b0, 0);
    rx_run(8'h81, 17, 1'b1, 0);
    tx_run(8'hFF, 9, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule